// File: doc/BRIEF.md
# Multiword DMA Host Sequencer

This block is the host-side engine of a parallel disk interface that moves 16-bit words with Multiword DMA handshaking. It waits for the device request line, asserts the acknowledge, and then issues read or write strobe pulses. Every phase of a pulse is a whole number of cycles of a fixed fast clock: the acknowledge setup before the first strobe, the active strobe width, the recovery gap and the acknowledge hold after the last strobe. A transfer is started with a word count and a direction. Write words come from a valid/ready source. Read words leave through a one-cycle valid pulse. A done flag reports that the whole count has moved.

A burst can end in two ways. The device may drop its request while a strobe is active, which makes that strobe's word the last of the burst. The host side may raise a stop input, which ends the burst after the word in flight. In both cases the acknowledge is released. The engine then waits for the request to return, or for the stop to clear, and resumes the remaining words in a new burst. The default timing parameters fit a 48 MHz clock: 1 cycle of acknowledge setup, 4 cycles of strobe, 2 cycles of recovery and 1 cycle of acknowledge hold. This gives a 125 ns word cycle, which meets the 120 ns minimum.

Top module: `mdma_host_seq`

## Requirements
- R1: While reset is asserted, `dmack_n_o`, `dior_n_o` and `diow_n_o` are high, `dd_oe_o`, `rd_valid_o`, `wr_ready_o` and `done_o` are low.
- R2: The acknowledge falls only on a clock edge at which `dmarq_i` was sampled high. With the request low the engine waits for as long as it takes.
- R3: Each strobe (`dior_n_o` or `diow_n_o`) stays low for exactly T_ACT cycles (default 4).
- R4: Between two strobes of the same burst the strobe stays high for at least T_REC cycles (default 2).
- R5: A strobe is asserted only while the acknowledge is low, and the two strobes are never low together. The acknowledge is low at least T_ACK_SU cycles (default 1) before the first strobe of a burst, and it stays low at least T_ACK_HLD cycles (default 1) after the last strobe rises.
- R6: With `rd_dir_i`=0 (write), `dd_oe_o` is high while strobes are issued. `dd_o` takes a new word only on the edge that pulls `diow_n_o` low and holds it through the pulse and past its rising edge. Words go out in the order the source supplied them.
- R7: With `rd_dir_i`=1 (read), `rd_valid_o` pulses for one cycle in the cycle `dior_n_o` returns high. `rd_data_o` then equals the `dd_i` value present in the final low cycle of that strobe. One pulse is produced per word.
- R8: If `dmarq_i` is seen low during an active strobe, that strobe carries the last word of the burst. The acknowledge is released before any further strobe, and the transfer resumes once the request is back.
- R9: No strobe begins on an edge at which `host_stop_i` was sampled high. A stop ends the burst after the current word, and the transfer resumes after the stop clears.
- R10: Exactly `xfer_words_i` strobes occur per transfer. `done_o` clears when a start is accepted and rises once the last acknowledge is released. It then stays high with the acknowledge released. A count of zero sets `done_o` without any acknowledge.
- R11: A write strobe starts only with a word accepted from the source. `wr_ready_o` is high only when `wr_valid_i` is high, with one handshake per word. Gaps in `wr_valid_i` stretch the recovery time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start a transfer (accepted when idle) |
| rd_dir_i | input | 1 | 1 = device to host, 0 = host to device |
| xfer_words_i | input | 16 | Number of words in the transfer |
| host_stop_i | input | 1 | Host request to end the current burst |
| wr_valid_i | input | 1 | Write word available |
| wr_data_i | input | 16 | Write word |
| wr_ready_o | output | 1 | Write word taken this cycle |
| rd_valid_o | output | 1 | Read word valid (one cycle) |
| rd_data_o | output | 16 | Read word |
| done_o | output | 1 | Transfer complete |
| dmarq_i | input | 1 | Device DMA request (active high) |
| dmack_n_o | output | 1 | DMA acknowledge (active low) |
| dior_n_o | output | 1 | Read strobe (active low) |
| diow_n_o | output | 1 | Write strobe (active low) |
| dd_o | output | 16 | Data bus out |
| dd_oe_o | output | 1 | Data bus output enable |
| dd_i | input | 16 | Data bus in |

## Verification
The bench sweeps both directions, word counts from zero to five, and four stimulus patterns: a plain burst, a request drop during the second strobe, a host stop during the first strobe, and a write source with gaps. A design that ignored the request drop would keep strobing under the same acknowledge, and a design that ignored the stop would issue a strobe right after it. A design that counted badly across a resumed burst would show the wrong strobe total or stall without done. Off-by-one phase counters show up as a strobe width other than four, a recovery below two, or an acknowledge that rises in the same cycle as the strobe. A read capture taken one cycle late or early returns a different bus value than the one present in the last low cycle.

// File: rtl/mdma_pkg.sv
package mdma_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_WAITRQ = 3'd1,
    ST_ACKSU  = 3'd2,
    ST_STROBE = 3'd3,
    ST_RECOV  = 3'd4,
    ST_ACKHLD = 3'd5
  } seq_st_t;

  function automatic int unsigned max_of4(int unsigned a, int unsigned b,
                                          int unsigned c, int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/mdma_phase_timer.sv
module mdma_phase_timer #(
  parameter int TW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [TW-1:0] val_i,
  output logic          exp_o
);

  logic [TW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)          cnt_d = val_i;
    else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign exp_o = (cnt_q == '0);

endmodule

// File: rtl/mdma_word_count.sv
module mdma_word_count #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [CW-1:0] val_i,
  input  logic          dec_i,
  output logic          zero_o,
  output logic          last_o
);

  logic [CW-1:0] left_q, left_d;

  always_comb begin
    left_d = left_q;
    if (load_i)     left_d = val_i;
    else if (dec_i) left_d = left_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) left_q <= '0;
    else        left_q <= left_d;
  end

  assign zero_o = (left_q == '0);
  assign last_o = (left_q == CW'(1));

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    dec_i |-> !zero_o); // R10

endmodule

// File: rtl/mdma_seq_fsm.sv
module mdma_seq_fsm
  import mdma_pkg::*;
#(
  parameter int T_ACK_SU  = 1,
  parameter int T_ACT     = 4,
  parameter int T_REC     = 2,
  parameter int T_ACK_HLD = 1,
  parameter int TW        = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          zero_i,
  input  logic          last_i,
  input  logic          t_exp_i,
  input  logic          dmarq_i,
  input  logic          host_stop_i,
  input  logic          rd_dir_i,
  input  logic          wr_valid_i,
  output seq_st_t       state_o,
  output logic          t_load_o,
  output logic [TW-1:0] t_val_o,
  output logic          dec_o,
  output logic          fin_o,
  output logic          wr_take_o,
  output logic          rd_take_o
);

  localparam logic [TW-1:0] LD_SU  = TW'(T_ACK_SU - 1);
  localparam logic [TW-1:0] LD_ACT = TW'(T_ACT - 1);
  localparam logic [TW-1:0] LD_REC = TW'(T_REC - 1);
  localparam logic [TW-1:0] LD_HLD = TW'(T_ACK_HLD - 1);

  seq_st_t st_q, st_d;
  logic    drop_q, drop_d;
  logic    word_ok;

  assign word_ok = rd_dir_i | wr_valid_i;

  always_comb begin
    st_d      = st_q;
    t_load_o  = 1'b0;
    t_val_o   = '0;
    dec_o     = 1'b0;
    fin_o     = 1'b0;
    wr_take_o = 1'b0;
    rd_take_o = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start_i) st_d = ST_WAITRQ;
      end
      ST_WAITRQ: begin
        if (zero_i) begin
          fin_o = 1'b1;
          st_d  = ST_IDLE;
        end else if (dmarq_i && !host_stop_i && word_ok) begin
          st_d     = ST_ACKSU;
          t_load_o = 1'b1;
          t_val_o  = LD_SU;
        end
      end
      ST_ACKSU: begin
        if (t_exp_i) begin
          if (host_stop_i) begin
            st_d     = ST_ACKHLD;
            t_load_o = 1'b1;
            t_val_o  = LD_HLD;
          end else if (word_ok) begin
            st_d      = ST_STROBE;
            t_load_o  = 1'b1;
            t_val_o   = LD_ACT;
            wr_take_o = !rd_dir_i;
          end
        end
      end
      ST_STROBE: begin
        if (t_exp_i) begin
          dec_o     = 1'b1;
          rd_take_o = rd_dir_i;
          t_load_o  = 1'b1;
          if (last_i || drop_q || !dmarq_i || host_stop_i) begin
            st_d    = ST_ACKHLD;
            t_val_o = LD_HLD;
          end else begin
            st_d    = ST_RECOV;
            t_val_o = LD_REC;
          end
        end
      end
      ST_RECOV: begin
        if (t_exp_i) begin
          if (host_stop_i || !dmarq_i) begin
            st_d     = ST_ACKHLD;
            t_load_o = 1'b1;
            t_val_o  = LD_HLD;
          end else if (word_ok) begin
            st_d      = ST_STROBE;
            t_load_o  = 1'b1;
            t_val_o   = LD_ACT;
            wr_take_o = !rd_dir_i;
          end
        end
      end
      ST_ACKHLD: begin
        if (t_exp_i) begin
          if (zero_i) begin
            fin_o = 1'b1;
            st_d  = ST_IDLE;
          end else begin
            st_d  = ST_WAITRQ;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    drop_d = 1'b0;
    if (st_q == ST_STROBE && st_d == ST_STROBE) drop_d = drop_q | !dmarq_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      drop_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      drop_q <= drop_d;
    end
  end

  assign state_o = st_q;

  AST_HOLD_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_STROBE && st_d != ST_STROBE) |-> (st_d == ST_RECOV || st_d == ST_ACKHLD)); // R5

endmodule

// File: rtl/mdma_host_seq.sv
module mdma_host_seq
  import mdma_pkg::*;
#(
  parameter int CW        = 16,
  parameter int DW        = 16,
  parameter int T_ACK_SU  = 1,
  parameter int T_ACT     = 4,
  parameter int T_REC     = 2,
  parameter int T_ACK_HLD = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          rd_dir_i,
  input  logic [CW-1:0] xfer_words_i,
  input  logic          host_stop_i,
  input  logic          wr_valid_i,
  input  logic [DW-1:0] wr_data_i,
  output logic          wr_ready_o,
  output logic          rd_valid_o,
  output logic [DW-1:0] rd_data_o,
  output logic          done_o,
  input  logic          dmarq_i,
  output logic          dmack_n_o,
  output logic          dior_n_o,
  output logic          diow_n_o,
  output logic [DW-1:0] dd_o,
  output logic          dd_oe_o,
  input  logic [DW-1:0] dd_i
);

  localparam int TMAX  = int'(max_of4(T_ACK_SU, T_ACT, T_REC, T_ACK_HLD));
  localparam int TW    = (TMAX < 2) ? 1 : $clog2(TMAX);
  localparam int RUN_W = $clog2(T_ACT + 2);

  seq_st_t       state;
  logic          t_load, t_exp, dec, fin, wr_take, rd_take;
  logic [TW-1:0] t_val;
  logic          zero, last;
  logic          start_acc;
  logic          rd_q, rd_d;
  logic          done_q, done_d;
  logic          rdv_q, rdv_d;
  logic [DW-1:0] rdd_q, rdd_d;
  logic [DW-1:0] wdd_q, wdd_d;
  logic          ack_on;

  assign start_acc = start_i && (state == ST_IDLE);

  mdma_phase_timer #(.TW(TW)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (t_load),
    .val_i  (t_val),
    .exp_o  (t_exp)
  );

  mdma_word_count #(.CW(CW)) u_count (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (start_acc),
    .val_i  (xfer_words_i),
    .dec_i  (dec),
    .zero_o (zero),
    .last_o (last)
  );

  mdma_seq_fsm #(
    .T_ACK_SU  (T_ACK_SU),
    .T_ACT     (T_ACT),
    .T_REC     (T_REC),
    .T_ACK_HLD (T_ACK_HLD),
    .TW        (TW)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .zero_i      (zero),
    .last_i      (last),
    .t_exp_i     (t_exp),
    .dmarq_i     (dmarq_i),
    .host_stop_i (host_stop_i),
    .rd_dir_i    (rd_q),
    .wr_valid_i  (wr_valid_i),
    .state_o     (state),
    .t_load_o    (t_load),
    .t_val_o     (t_val),
    .dec_o       (dec),
    .fin_o       (fin),
    .wr_take_o   (wr_take),
    .rd_take_o   (rd_take)
  );

  always_comb begin
    rd_d   = start_acc ? rd_dir_i : rd_q;
    done_d = start_acc ? 1'b0 : (fin ? 1'b1 : done_q);
    rdv_d  = rd_take;
    rdd_d  = rd_take ? dd_i : rdd_q;
    wdd_d  = wr_take ? wr_data_i : wdd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q   <= 1'b0;
      done_q <= 1'b0;
      rdv_q  <= 1'b0;
      rdd_q  <= '0;
      wdd_q  <= '0;
    end else begin
      rd_q   <= rd_d;
      done_q <= done_d;
      rdv_q  <= rdv_d;
      rdd_q  <= rdd_d;
      wdd_q  <= wdd_d;
    end
  end

  assign ack_on     = (state == ST_ACKSU) || (state == ST_STROBE) ||
                      (state == ST_RECOV) || (state == ST_ACKHLD);
  assign dmack_n_o  = !ack_on;
  assign dior_n_o   = !((state == ST_STROBE) && rd_q);
  assign diow_n_o   = !((state == ST_STROBE) && !rd_q);
  assign dd_oe_o    = ack_on && !rd_q;
  assign dd_o       = wdd_q;
  assign wr_ready_o = wr_take;
  assign rd_valid_o = rdv_q;
  assign rd_data_o  = rdd_q;
  assign done_o     = done_q;

  // strobe low-run counter used only by the width check
  logic             stb_low;
  logic [RUN_W-1:0] a_run_q;
  assign stb_low = !(dior_n_o && diow_n_o);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             a_run_q <= '0;
    else if (!stb_low)                      a_run_q <= '0;
    else if (a_run_q != {RUN_W{1'b1}})      a_run_q <= a_run_q + 1'b1;
  end

  AST_ACK_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dmack_n_o) |-> $past(dmarq_i)); // R2
  AST_STROBE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dior_n_o && diow_n_o) |-> (a_run_q == RUN_W'(T_ACT))); // R3
  AST_STROBE_IN_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    stb_low |-> (!dmack_n_o && (dior_n_o || diow_n_o))); // R5
  AST_RDV_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_o |-> $rose(dior_n_o)); // R7
  AST_NO_STROBE_ON_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dior_n_o && diow_n_o) |-> !$past(host_stop_i)); // R9
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> dmack_n_o); // R10
  AST_READY_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready_o |-> wr_valid_i); // R11

endmodule

// File: tb/sim_mdma_host_seq.sv
module sim_mdma_host_seq;

  localparam int CW = 16;
  localparam int DW = 16;
  localparam int T_ACK_SU  = 1;
  localparam int T_ACT     = 4;
  localparam int T_REC     = 2;
  localparam int T_ACK_HLD = 1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start_i, rd_dir_i, host_stop_i, wr_valid_i, dmarq_i;
  logic [CW-1:0] xfer_words_i;
  logic [DW-1:0] wr_data_i, dd_i;
  logic          wr_ready_o, rd_valid_o, done_o, dmack_n_o, dior_n_o, diow_n_o, dd_oe_o;
  logic [DW-1:0] rd_data_o, dd_o;

  always #4 clk = ~clk;

  mdma_host_seq #(
    .CW(CW), .DW(DW), .T_ACK_SU(T_ACK_SU), .T_ACT(T_ACT),
    .T_REC(T_REC), .T_ACK_HLD(T_ACK_HLD)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .rd_dir_i(rd_dir_i),
    .xfer_words_i(xfer_words_i), .host_stop_i(host_stop_i),
    .wr_valid_i(wr_valid_i), .wr_data_i(wr_data_i), .wr_ready_o(wr_ready_o),
    .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o), .done_o(done_o),
    .dmarq_i(dmarq_i), .dmack_n_o(dmack_n_o), .dior_n_o(dior_n_o),
    .diow_n_o(diow_n_o), .dd_o(dd_o), .dd_oe_o(dd_oe_o), .dd_i(dd_i)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor state
  int acc = 0, ddi_ctr = 0;
  int n_stb, n_rd, n_wr, n_burst;
  int low_run = 0, high_run = 0, ack_age = 0, post_run = 0;
  bit hs_pend = 0, first_in_burst = 1, drop_seen = 0, need_rel = 0;
  bit xfer_rd = 0;
  bit p_stb = 0, p_dior_low = 0, p_ack_n = 1, p_dmarq = 0, p_stop = 0;
  logic [DW-1:0] dd_at_fall = '0;

  assign wr_data_i = DW'(16'hA000 + acc);
  assign dd_i      = DW'((ddi_ctr * 37) ^ 16'h3C00);

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      automatic bit stb  = !dior_n_o || !diow_n_o;
      automatic bit fall = stb && !p_stb;
      automatic bit rise = !stb && p_stb;
      if (!p_ack_n && dmack_n_o) begin
        need_rel = 0;
        if (!first_in_burst) chk(post_run >= T_ACK_HLD, "R5 ack hold after strobe", post_run, T_ACK_HLD);
      end
      if (p_ack_n && !dmack_n_o) begin
        chk(p_dmarq, "R2 request seen before ack", p_dmarq, 1);
        first_in_burst = 1;
        n_burst++;
      end
      if (fall) begin
        chk(!dmack_n_o, "R5 strobe inside ack", dmack_n_o, 0);
        chk(dior_n_o || diow_n_o, "R5 single strobe", 0, 1);
        chk(!p_stop, "R9 no strobe after stop", p_stop, 0);
        chk(!need_rel, "R8 ack released before next strobe", need_rel, 0);
        if (first_in_burst) chk(ack_age >= T_ACK_SU, "R5 ack lead", ack_age, T_ACK_SU);
        else                chk(high_run >= T_REC, "R4 recovery", high_run, T_REC);
        if (xfer_rd) chk(!dior_n_o, "R7 read strobe used", dior_n_o, 0);
        else begin
          chk(!diow_n_o && dd_oe_o, "R6 write strobe with drive", dd_oe_o, 1);
          chk(dd_o == DW'(16'hA000 + n_stb), "R6 word order", dd_o, 16'hA000 + n_stb);
          dd_at_fall = dd_o;
        end
        n_stb++;
        first_in_burst = 0;
        drop_seen = 0;
      end
      if (stb && !dmarq_i) drop_seen = 1;
      if (rise) begin
        chk(low_run == T_ACT, "R3 strobe width", low_run, T_ACT);
        if (!xfer_rd) chk(dd_o == dd_at_fall, "R6 data hold past strobe", dd_o, dd_at_fall);
        if (drop_seen) need_rel = 1;
      end
      if (rd_valid_o) begin
        chk(rise && p_dior_low, "R7 valid with read strobe rise", rise, 1);
        chk(rd_data_o == dd_i, "R7 captured word", rd_data_o, dd_i);
        n_rd++;
      end
      if (wr_ready_o && !wr_valid_i) chk(0, "R11 ready without valid", 1, 0);
      if (hs_pend) acc++;
      hs_pend = wr_ready_o && wr_valid_i;
      if (hs_pend) n_wr++;
      low_run  = stb ? low_run + 1 : 0;
      high_run = stb ? 0 : high_run + 1;
      ack_age  = !dmack_n_o ? ack_age + 1 : 0;
      post_run = (!dmack_n_o && !stb && !first_in_burst) ? post_run + 1 : 0;
      p_stb = stb; p_dior_low = !dior_n_o; p_ack_n = dmack_n_o;
      p_dmarq = dmarq_i; p_stop = host_stop_i;
      ddi_ctr++;
    end
  end

  // scen: 0 plain, 1 device drop on 2nd strobe, 2 host stop on 1st strobe, 3 write source gaps
  task automatic run_xfer(bit rd, int words, int scen);
    int phase, hold, t;
    @(posedge clk); #1;
    n_stb = 0; n_rd = 0; n_wr = 0; n_burst = 0; acc = 0; hs_pend = 0; need_rel = 0;
    xfer_rd = rd; rd_dir_i = rd; xfer_words_i = CW'(words);
    dmarq_i = 0; host_stop_i = 0; wr_valid_i = 1; start_i = 1;
    @(posedge clk); #1;
    start_i = 0;
    chk(!done_o, "R10 done cleared by start", done_o, 0);
    phase = 0; hold = 0; t = 0;
    while (!done_o && t < 3000) begin
      if (t == 3 && !(scen == 1 && phase != 0)) dmarq_i = 1;
      if (scen == 1) begin
        if (phase == 0 && n_stb >= 2) begin dmarq_i = 0; hold = 5; phase = 1; end
        else if (phase == 1) begin hold--; if (hold == 0) begin dmarq_i = 1; phase = 2; end end
      end
      if (scen == 2) begin
        if (phase == 0 && n_stb >= 1) begin host_stop_i = 1; hold = 8; phase = 1; end
        else if (phase == 1) begin hold--; if (hold == 0) begin host_stop_i = 0; phase = 2; end end
      end
      if (scen == 3) wr_valid_i = ((t % 3) != 1);
      @(posedge clk); #1;
      t++;
    end
    chk(done_o, "R10 done after transfer", done_o, 1);
    chk(n_stb == words, "R10 strobe total", n_stb, words);
    if (rd) chk(n_rd == words, "R7 read word total", n_rd, words);
    else    chk(n_wr == words, "R11 handshake total", n_wr, words);
    if (words == 0) chk(n_burst == 0, "R10 zero count without ack", n_burst, 0);
    if (scen == 1 && words >= 3) chk(n_burst >= 2, "R8 resumed after drop", n_burst, 2);
    if (scen == 2 && words >= 2) chk(n_burst >= 2, "R9 resumed after stop", n_burst, 2);
    dmarq_i = 0; wr_valid_i = 0;
    repeat (3) @(posedge clk); #1;
    chk(done_o && dmack_n_o, "R10 done held idle", done_o, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; start_i = 0; rd_dir_i = 0; xfer_words_i = '0; host_stop_i = 0;
    wr_valid_i = 0; dmarq_i = 1;
    repeat (3) @(posedge clk); #1;
    chk(dmack_n_o && dior_n_o && diow_n_o, "R1 control lines idle", dmack_n_o, 1);
    chk(!dd_oe_o && !rd_valid_o && !wr_ready_o && !done_o, "R1 outputs quiet", done_o, 0);
    dmarq_i = 0;
    rst_n = 1;
    for (int rd = 0; rd < 2; rd++)
      for (int sc = 0; sc < 4; sc++)
        for (int w = 0; w <= 5; w++)
          run_xfer(rd[0], w, sc);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule